// File: doc/BRIEF.md
# SPI Serial Memory Slave Engine

This block is a mode-0 SPI slave in front of a byte-wide memory array that the host sees as an 18-bit address space. The host lowers chip select and sends a command byte. For array transfers three address bytes follow, and then data bytes stream in or out with no gaps. After every byte the address moves up by one, until chip select rises. A write needs an earlier, separate frame that sets a write-enable latch. Each completed byte goes into the array at once, so there is no page buffer and no busy state.

The engine runs on a fast system clock and synchronizes SCK, chip select and MOSI into that clock. Data is sampled on SCK rising edges, and MISO changes on falling edges. A write-protect unit outside the block sees the current address and the status fields. It returns two allow flags: one for the array byte at that address and one for the status register. The array depth is a parameter. Addresses above the depth alias onto the array through their low bits, while the counter itself stays 18 bits wide.

Top module: `spi_mem_slave`

## Requirements
- R1: Command 06h sets the write-enable latch and command 04h clears it. The latch reads back as bit 1 of the status byte.
- R2: Command 05h returns the status byte on MISO, repeated for every further byte of the frame. Bit 7 is the protect-enable flag, bit 6 is always 1, bits 3:2 are the block-protect field, bit 1 is the latch, and bits 5, 4 and 0 are 0, so the busy bit 0 never reads 1.
- R3: Command 01h takes one byte and loads bit 7 into the protect-enable flag and bits 3:2 into the block-protect field. The load happens only when the latch is set and wp_sr_ok is high.
- R4: Command 02h is followed by three address bytes, most significant first. The top 6 bits of the first address byte are ignored. Each data byte is stored at the current address on its 8th rising SCK edge, if the latch is set and wp_mem_ok is high.
- R5: The address goes up by one after every data byte, in reads and in writes, and wraps from 3FFFFh to 00000h.
- R6: Command 03h with three address bytes returns data MSB first. Each bit changes on a falling SCK edge and holds through the next rising edge, and MOSI has no effect.
- R7: When chip select rises at the end of a 02h or 01h frame, the write-enable latch clears.
- R8: A byte cut short by chip select rising is not written.
- R9: An unknown command byte makes the rest of its frame have no effect, even if that frame later carries 06h.
- R10: MISO is high-impedance while chip select is high.
- R11: A data byte refused by wp_mem_ok is dropped, but the address still goes up by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the SPI pins |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_sck | input | 1 | SPI clock, mode 0 |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, high-impedance when deselected |
| wp_addr | output | 18 | Current transfer address, to the protect unit |
| wp_bp | output | 2 | Block-protect field |
| wp_wpen | output | 1 | Status protect-enable flag |
| wp_mem_ok | input | 1 | Protect unit allows an array write at wp_addr |
| wp_sr_ok | input | 1 | Protect unit allows a status write |

## Verification
The hardest case to reach from the ports is a dropped byte whose address still advances. Proving it needs a protected byte followed by an unprotected one at the next address. The stimulus sets the upper-quarter protect field, then starts a write at 3FFFFh so that the burst wraps into 00000h. The write at 00000h lands only if the refused byte still advanced the counter. Cut-short bytes are reached by raising chip select four bits into a byte, and a rejected status write by holding the bench's hardware protect pin low.

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int DEPTH = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sck,
  input  logic        spi_cs_n,
  input  logic        spi_mosi,
  output logic        spi_miso,
  output logic [17:0] wp_addr,
  output logic [1:0]  wp_bp,
  output logic        wp_wpen,
  input  logic        wp_mem_ok,
  input  logic        wp_sr_ok
);
  localparam int AW = $clog2(DEPTH);

  typedef enum logic [2:0] {S_OPC, S_ADR, S_RD, S_WR, S_SRR, S_SRW, S_IGN} st_t;

  logic [2:0]  sck_p;
  logic [1:0]  cs_p, mosi_p;
  logic [2:0]  bitcnt;
  logic [1:0]  adr_cnt;
  logic [6:0]  shreg;
  logic [7:0]  tx;
  logic [17:0] addr;
  logic [1:0]  bp;
  logic        wel, wpen, rd_op, wr_frame;
  st_t         state;
  logic [7:0]  mem [DEPTH];

  wire       sck_rise  = sck_p[1] & ~sck_p[2];
  wire       sck_fall  = ~sck_p[1] & sck_p[2];
  wire       cs_idle   = cs_p[1];
  wire [7:0] rx_byte   = {shreg, mosi_p[1]};
  wire       byte_done = sck_rise && !cs_idle && bitcnt == 3'd7;
  wire       we        = byte_done && state == S_WR && wel && wp_mem_ok;
  wire       load      = sck_fall && bitcnt == 3'd0;
  wire [7:0] status    = {wpen, 1'b1, 2'b00, bp, wel, 1'b0};
  wire [7:0] mem_rd    = mem[addr[AW-1:0]];

  assign spi_miso = spi_cs_n ? 1'bz : tx[7];
  assign wp_addr  = addr;
  assign wp_bp    = bp;
  assign wp_wpen  = wpen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_p  <= 3'b000;
      cs_p   <= 2'b11;
      mosi_p <= 2'b00;
    end else begin
      sck_p  <= {sck_p[1:0], spi_sck};
      cs_p   <= {cs_p[0], spi_cs_n};
      mosi_p <= {mosi_p[0], spi_mosi};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_OPC; bitcnt <= '0; adr_cnt <= '0; shreg <= '0;
      addr <= '0; wel <= 1'b0; wpen <= 1'b0; bp <= '0;
      rd_op <= 1'b0; wr_frame <= 1'b0;
    end else if (cs_idle) begin
      state <= S_OPC; bitcnt <= '0; adr_cnt <= '0;
      if (wr_frame) wel <= 1'b0;
      wr_frame <= 1'b0;
    end else begin
      if (sck_rise) begin
        shreg  <= rx_byte[6:0];
        bitcnt <= bitcnt + 3'd1;
      end
      if (byte_done) begin
        case (state)
          S_OPC: begin
            case (rx_byte)
              8'h06: begin wel <= 1'b1; state <= S_IGN; end
              8'h04: begin wel <= 1'b0; state <= S_IGN; end
              8'h05: state <= S_SRR;
              8'h01: begin state <= S_SRW; wr_frame <= 1'b1; end
              8'h03: begin state <= S_ADR; rd_op <= 1'b1; end
              8'h02: begin state <= S_ADR; rd_op <= 1'b0; wr_frame <= 1'b1; end
              default: state <= S_IGN;
            endcase
          end
          S_ADR: begin
            addr    <= {addr[9:0], rx_byte};
            adr_cnt <= adr_cnt + 2'd1;
            if (adr_cnt == 2'd2) state <= rd_op ? S_RD : S_WR;
          end
          S_WR: addr <= addr + 18'd1;
          S_SRW: begin
            if (wel && wp_sr_ok) begin
              wpen <= rx_byte[7];
              bp   <= rx_byte[3:2];
            end
            state <= S_IGN;
          end
          default: ;
        endcase
      end
      if (load && state == S_RD) addr <= addr + 18'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      tx <= '0;
    else if (sck_fall) begin
      if (load && state == S_RD)       tx <= mem_rd;
      else if (load && state == S_SRR) tx <= status;
      else                             tx <= {tx[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[addr[AW-1:0]] <= rx_byte;
  end

  p_wel_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(byte_done && state == S_OPC && rx_byte == 8'h06));

  p_sr_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({wpen, bp}) |-> $past(wel && wp_sr_ok && state == S_SRW && byte_done));

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> wp_addr == $past(wp_addr) + 18'd1);

  p_tx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_fall |=> $stable(tx));

  p_wel_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wel) |-> ($past(cs_idle) || $past(byte_done && state == S_OPC && rx_byte == 8'h04)));
endmodule

// File: tb/spi_mem_slave_tb.sv
`timescale 1ns/1ps
module spi_mem_slave_tb;
  localparam int DEPTH = 1024;
  localparam int MASK  = DEPTH - 1;

  logic clk = 0, rst_n = 0;
  logic sck = 0, cs_n = 1, mosi = 0, wp_pin = 1;
  wire  miso;
  wire [17:0] wp_addr;
  wire [1:0]  wp_bp;
  wire        wp_wpen;
  logic       wp_mem_ok, wp_sr_ok;

  int checks = 0, errors = 0;
  bit hold_chk = 0;

  logic [7:0] txq[$], rxq[$];
  logic [7:0] m_mem [int];
  logic       m_wel = 0, m_wpen = 0;
  logic [1:0] m_bp = 0;

  always #2.5 clk = ~clk;

  function automatic bit prot(input logic [1:0] b, input logic [17:0] a);
    case (b)
      2'd0: return 0;
      2'd1: return a >= 18'h30000;
      2'd2: return a >= 18'h20000;
      default: return 1;
    endcase
  endfunction

  assign wp_mem_ok = !prot(wp_bp, wp_addr);
  assign wp_sr_ok  = !(wp_wpen && !wp_pin);

  spi_mem_slave #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .wp_addr(wp_addr), .wp_bp(wp_bp), .wp_wpen(wp_wpen),
    .wp_mem_ok(wp_mem_ok), .wp_sr_ok(wp_sr_ok));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // R10: every clock while deselected
  always @(negedge clk)
    if (rst_n && cs_n) chk(miso === 1'bz, "R10 miso not high-z", {31'd0, miso}, 32'd0);

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] o, output logic [7:0] i);
    for (int b = 7; b >= 0; b--) begin
      mosi = o[b];
      half();
      i[b] = miso;
      sck = 1;
      half();
      if (hold_chk) chk(miso === i[b], "R6 miso moved while sck high", {31'd0, miso}, {31'd0, i[b]});
      sck = 0;
    end
  endtask

  task automatic frame(input int extra_bits);
    logic [7:0] r;
    rxq.delete();
    cs_n = 0;
    half();
    foreach (txq[k]) begin
      xfer(txq[k], r);
      rxq.push_back(r);
    end
    for (int b = 0; b < extra_bits; b++) begin
      mosi = 1; half(); sck = 1; half(); sck = 0;
    end
    half();
    cs_n = 1;
    repeat (24) @(negedge clk);
  endtask

  function automatic logic [7:0] m_stat();
    return {m_wpen, 1'b1, 2'b00, m_bp, m_wel, 1'b0};
  endfunction

  task automatic cmd(input logic [7:0] op);
    txq.delete(); txq.push_back(op);
    frame(0);
    if (op == 8'h06) m_wel = 1;
    if (op == 8'h04) m_wel = 0;
  endtask

  task automatic rdsr(input string tag);
    txq.delete(); txq.push_back(8'h05); txq.push_back(8'h33); txq.push_back(8'hCC);
    frame(0);
    chk(rxq[1] === m_stat(), tag, {24'd0, rxq[1]}, {24'd0, m_stat()});
    chk(rxq[2] === m_stat(), {tag, " (R2 repeat)"}, {24'd0, rxq[2]}, {24'd0, m_stat()});
  endtask

  task automatic wrsr(input logic [7:0] v);
    txq.delete(); txq.push_back(8'h01); txq.push_back(v);
    frame(0);
    if (m_wel && !(m_wpen && !wp_pin)) begin m_wpen = v[7]; m_bp = v[3:2]; end
    m_wel = 0;
  endtask

  task automatic write(input logic [17:0] a, input logic [7:0] d[$], input int partial);
    logic [17:0] p = a;
    txq.delete();
    txq.push_back(8'h02); txq.push_back({6'b101100, a[17:16]});
    txq.push_back(a[15:8]); txq.push_back(a[7:0]);
    foreach (d[k]) txq.push_back(d[k]);
    frame(partial);
    foreach (d[k]) begin
      if (m_wel && !prot(m_bp, p)) m_mem[int'(p) & MASK] = d[k];
      p = p + 18'd1;
    end
    m_wel = 0;
  endtask

  task automatic read(input logic [17:0] a, input int n, input logic [5:0] junk, input string tag);
    logic [17:0] p = a;
    txq.delete();
    txq.push_back(8'h03); txq.push_back({junk, a[17:16]});
    txq.push_back(a[15:8]); txq.push_back(a[7:0]);
    for (int k = 0; k < n; k++) txq.push_back(k[0] ? 8'hA5 : 8'h5A);
    hold_chk = 1;
    frame(0);
    hold_chk = 0;
    for (int k = 0; k < n; k++) begin
      int ix = int'(p) & MASK;
      if (m_mem.exists(ix))
        chk(rxq[4+k] === m_mem[ix], tag, {24'd0, rxq[4+k]}, {24'd0, m_mem[ix]});
      p = p + 18'd1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] q[$];
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);

    rdsr("R2 reset status");

    cmd(8'h06); rdsr("R1 latch set");
    cmd(8'h04); rdsr("R1 latch cleared");

    cmd(8'h06); q = '{8'h11}; write(18'h00100, q, 0);
    rdsr("R7 latch cleared after write frame");
    q = '{8'h22}; write(18'h00100, q, 0);
    read(18'h00100, 1, 6'd0, "R4 write without latch dropped");

    cmd(8'h06); q = '{8'hDE, 8'hAD, 8'hBE, 8'hEF}; write(18'h00200, q, 0);
    read(18'h00200, 4, 6'd0, "R4/R5/R6 burst");
    read(18'h00200, 4, 6'h3F, "R4 top address bits ignored");

    cmd(8'h06); q = '{8'hA1, 8'hA2, 8'hA3}; write(18'h3FFFE, q, 0);
    read(18'h3FFFE, 3, 6'd0, "R5 wrap");

    cmd(8'h06); wrsr(8'h84); rdsr("R3/R7 status write");

    cmd(8'h06); q = '{8'hE1, 8'hE2}; write(18'h3FFFF, q, 0);
    read(18'h3FFFF, 2, 6'd0, "R11 protected byte dropped, address advanced");
    cmd(8'h06); q = '{8'h5C, 8'h6D}; write(18'h2FFFF, q, 0);
    read(18'h2FFFF, 2, 6'd0, "R11 protect boundary");

    wp_pin = 0;
    cmd(8'h06); wrsr(8'h00); rdsr("R3 status write refused");
    wp_pin = 1;
    cmd(8'h06); wrsr(8'h00); rdsr("R3 status write allowed");

    cmd(8'h06); q = '{8'h55, 8'h99}; write(18'h00300, q, 0);
    cmd(8'h06);
    txq.delete();
    txq.push_back(8'h02); txq.push_back(8'h00); txq.push_back(8'h03); txq.push_back(8'h00);
    txq.push_back(8'h77);
    frame(4);
    m_mem[18'h300 & MASK] = 8'h77; m_wel = 0;
    read(18'h00300, 2, 6'd0, "R8 partial byte discarded");

    txq.delete(); txq.push_back(8'hAB); txq.push_back(8'h06); txq.push_back(8'h06);
    frame(0);
    rdsr("R9 unknown opcode ignored");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule